// File: doc/BRIEF.md
# Adaptive Equalizer Search Controller

This block drives the search for a working receiver equalizer setting. It holds a 4-bit equalizer code and a 3-bit filter code. It waits a programmable settling time after each setting and then judges the link from a lock indicator and three error strobes. A setting that fails is replaced by the next one in a fixed search order. A setting that passes puts the controller into an adapted state, where it keeps watching the error rate.

Validation can run in one of two ways. In one-step mode the controller waits out the whole relock period, then requires lock and an error count no higher than a threshold. In two-step mode it settles for half the period, then watches errors for the other half, and any counted error rejects the setting at once. The filter code can join the search as a nested loop, and either code can be chosen as the inner one. Once adapted, the controller rejects the setting when too many errors arrive within one half-period window.

Top module: `eq_search_ctrl`

## Requirements
- R1: A synchronous active-high reset sets both codes to 0, clears the adapted output and starts a fresh settling phase.
- R2: Each cycle, each error strobe whose mask bit is set adds one to the window count: mask bit 2 selects the clock-bit strobe, bit 1 the control-sequence strobe and bit 0 the parity strobe. A mask of 0 counts nothing.
- R3: The half period H is the relock period shifted right by one, with 0 read as 1. With two-step mode off, a setting is judged at the 2H-th clock edge after it was applied. It passes when lock is high and the count over the last H cycles is no greater than the threshold. Otherwise the next setting is applied on that edge.
- R4: With two-step mode on, errors during the first H cycles are ignored. A counted error during the second H cycles applies the next setting on that same clock edge. Reaching the end of the second half with lock high enters the adapted state.
- R5: A programmed threshold of 0 behaves exactly like a threshold of 1.
- R6: The window error count saturates at 255 and starts from 0 in every window.
- R7: With filter adaption off, each advance adds one to the equalizer code (15 wraps to 0) and leaves the filter code unchanged.
- R8: With filter adaption on and outer select 0, the equalizer code is inner: from 15 it wraps to 0 and the filter code adds one, and from codes 15 and 7 both return to 0.
- R9: With filter adaption on and outer select 1, the filter code is inner: from 7 it wraps to 0 and the equalizer code adds one.
- R10: In the adapted state, errors are counted over consecutive windows of H cycles. A window that ends with a count above the threshold applies the next setting and restarts validation from the settling phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_i | input | 1 | Receiver lock indicator |
| err_clk_i | input | 1 | Clock-bit error strobe |
| err_seq_i | input | 1 | Control-sequence error strobe |
| err_par_i | input | 1 | Parity error strobe |
| relock_period_i | input | 16 | Full relock period in cycles |
| err_mask_i | input | 3 | Error class enables (bit 2 clock, bit 1 sequence, bit 0 parity) |
| err_thresh_i | input | 8 | Error threshold, 0 treated as 1 |
| two_step_i | input | 1 | Select two-phase validation |
| outer_sel_i | input | 1 | 0: filter outer loop, 1: equalizer outer loop |
| flt_adapt_i | input | 1 | Include the filter code in the search |
| eq_code_o | output | 4 | Current equalizer code |
| flt_code_o | output | 3 | Current filter code |
| adapted_o | output | 1 | Setting validated |

## Verification
All three outputs are registered, so the result of any decision becomes visible one nanosecond after the clock edge that ends the window, or after the edge that samples an early two-step error. The bench drives every input between edges and advances a cycle-level reference model of the requirements at each edge. It compares all outputs 1 ns after the edge. Directed cases also check fixed expected codes at the edges where the requirements place a decision: the 2H-th edge, the edge of the error, and the window end.

// File: rtl/eqs_pkg.sv
package eqs_pkg;

  typedef enum logic [1:0] {
    ST_SETTLE = 2'd0,
    ST_PROBE  = 2'd1,
    ST_HOLD   = 2'd2
  } eqs_state_e;

  function automatic logic [1:0] count_hits(input logic [2:0] v);
    count_hits = {1'b0, v[0]} + {1'b0, v[1]} + {1'b0, v[2]};
  endfunction

endpackage

// File: rtl/eqs_phase_timer.sv
module eqs_phase_timer #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [CNT_W-1:0] half_len,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  assign done = (cnt_q == half_len - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/eqs_err_acc.sv
module eqs_err_acc
  import eqs_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic [2:0]       strobes,
  input  logic [2:0]       mask,
  output logic             hit,
  output logic [CNT_W-1:0] cnt_nx
);
  localparam logic [CNT_W+1:0] SAT = {2'b00, {CNT_W{1'b1}}};

  logic [CNT_W-1:0] cnt_q;
  logic [1:0]       inc;
  logic [CNT_W+1:0] sum;

  always_comb begin
    inc    = count_hits(strobes & mask);
    hit    = (inc != 2'd0);
    sum    = {2'b00, cnt_q} + {{CNT_W{1'b0}}, inc};
    cnt_nx = (sum > SAT) ? SAT[CNT_W-1:0] : sum[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (en)    cnt_q <= cnt_nx;
  end
endmodule

// File: rtl/eqs_code_step.sv
module eqs_code_step #(
  parameter int EQ_W  = 4,
  parameter int FLT_W = 3
) (
  input  logic [EQ_W-1:0]  eq_in,
  input  logic [FLT_W-1:0] flt_in,
  input  logic             nest_en,
  input  logic             eq_outer,
  output logic [EQ_W-1:0]  eq_out,
  output logic [FLT_W-1:0] flt_out
);
  localparam logic [EQ_W-1:0]  EQ_MAX  = {EQ_W{1'b1}};
  localparam logic [FLT_W-1:0] FLT_MAX = {FLT_W{1'b1}};

  always_comb begin
    eq_out  = eq_in;
    flt_out = flt_in;
    if (!nest_en) begin
      eq_out = eq_in + 1'b1;
    end else if (!eq_outer) begin
      eq_out = eq_in + 1'b1;
      if (eq_in == EQ_MAX) flt_out = flt_in + 1'b1;
    end else begin
      flt_out = flt_in + 1'b1;
      if (flt_in == FLT_MAX) eq_out = eq_in + 1'b1;
    end
  end
endmodule

// File: rtl/eq_search_ctrl.sv
module eq_search_ctrl
  import eqs_pkg::*;
#(
  parameter int PER_W = 16,
  parameter int ERR_W = 8,
  parameter int EQ_W  = 4,
  parameter int FLT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lock_i,
  input  logic             err_clk_i,
  input  logic             err_seq_i,
  input  logic             err_par_i,
  input  logic [PER_W-1:0] relock_period_i,
  input  logic [2:0]       err_mask_i,
  input  logic [ERR_W-1:0] err_thresh_i,
  input  logic             two_step_i,
  input  logic             outer_sel_i,
  input  logic             flt_adapt_i,
  output logic [EQ_W-1:0]  eq_code_o,
  output logic [FLT_W-1:0] flt_code_o,
  output logic             adapted_o
);
  localparam int HALF_W = PER_W - 1;

  eqs_state_e       st_q, st_nx;
  logic [HALF_W-1:0] half_len;
  logic [ERR_W-1:0]  thr_eff;
  logic              win_done, err_hit, advance, win_clr;
  logic [ERR_W-1:0]  err_cnt_nx;
  logic [EQ_W-1:0]   eq_step;
  logic [FLT_W-1:0]  flt_step;

  always_comb begin
    half_len = relock_period_i[PER_W-1:1];
    if (half_len == '0) half_len = {{(HALF_W-1){1'b0}}, 1'b1};
    thr_eff = (err_thresh_i == '0) ? {{(ERR_W-1){1'b0}}, 1'b1} : err_thresh_i;
  end

  eqs_phase_timer #(.CNT_W(HALF_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .clr      (win_clr),
    .half_len (half_len),
    .done     (win_done)
  );

  eqs_err_acc #(.CNT_W(ERR_W)) u_acc (
    .clk     (clk),
    .rst     (rst),
    .clr     (win_clr),
    .en      (st_q != ST_SETTLE),
    .strobes ({err_clk_i, err_seq_i, err_par_i}),
    .mask    (err_mask_i),
    .hit     (err_hit),
    .cnt_nx  (err_cnt_nx)
  );

  eqs_code_step #(.EQ_W(EQ_W), .FLT_W(FLT_W)) u_step (
    .eq_in    (eq_code_o),
    .flt_in   (flt_code_o),
    .nest_en  (flt_adapt_i),
    .eq_outer (outer_sel_i),
    .eq_out   (eq_step),
    .flt_out  (flt_step)
  );

  always_comb begin
    st_nx   = st_q;
    advance = 1'b0;
    unique case (st_q)
      ST_SETTLE: if (win_done) st_nx = ST_PROBE;
      ST_PROBE: begin
        if (two_step_i && err_hit) begin
          advance = 1'b1;
        end else if (win_done) begin
          if (lock_i && (two_step_i || err_cnt_nx <= thr_eff)) st_nx = ST_HOLD;
          else advance = 1'b1;
        end
      end
      ST_HOLD: if (win_done && err_cnt_nx > thr_eff) advance = 1'b1;
      default: st_nx = ST_SETTLE;
    endcase
    if (advance) st_nx = ST_SETTLE;
    win_clr = win_done || advance;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_SETTLE;
      eq_code_o  <= '0;
      flt_code_o <= '0;
      adapted_o  <= 1'b0;
    end else begin
      st_q      <= st_nx;
      adapted_o <= (st_nx == ST_HOLD);
      if (advance) begin
        eq_code_o  <= eq_step;
        flt_code_o <= flt_step;
      end
    end
  end
endmodule

// File: rtl/eqs_checker.sv
module eqs_checker #(
  parameter int EQ_W  = 4,
  parameter int FLT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             flt_adapt_i,
  input logic [EQ_W-1:0]  eq_code_o,
  input logic [FLT_W-1:0] flt_code_o,
  input logic             adapted_o
);
  // R1: reset leaves zero codes and no adapted flag
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (eq_code_o == '0 && flt_code_o == '0 && !adapted_o));

  // R7: without filter adaption a code change is a single equalizer step
  a_r7_eq_single_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(flt_adapt_i) && eq_code_o != $past(eq_code_o))
      |-> (eq_code_o == EQ_W'($past(eq_code_o) + 1'b1) && flt_code_o == $past(flt_code_o)));

  // R10: leaving the adapted state always applies a new setting
  a_r10_exit_moves_code: assert property (@(posedge clk) disable iff (rst)
    ($fell(adapted_o) && !$past(rst))
      |-> (eq_code_o != $past(eq_code_o) || flt_code_o != $past(flt_code_o)));

  // R3: a newly applied setting is never reported as adapted
  a_r3_new_code_not_adapted: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (!$stable(eq_code_o) || !$stable(flt_code_o))) |-> !adapted_o);

  // R4: entering the adapted state keeps the setting that was validated
  a_r4_adapt_keeps_code: assert property (@(posedge clk) disable iff (rst)
    ($rose(adapted_o) && !$past(rst)) |-> ($stable(eq_code_o) && $stable(flt_code_o)));
endmodule

bind eq_search_ctrl eqs_checker #(.EQ_W(EQ_W), .FLT_W(FLT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .flt_adapt_i (flt_adapt_i),
  .eq_code_o   (eq_code_o),
  .flt_code_o  (flt_code_o),
  .adapted_o   (adapted_o)
);

// File: tb/eq_search_ctrl_tb.sv
module eq_search_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lock_i = 1'b0;
  logic        err_clk_i = 1'b0, err_seq_i = 1'b0, err_par_i = 1'b0;
  logic [15:0] relock_period_i = 16'd10;
  logic [2:0]  err_mask_i = 3'd0;
  logic [7:0]  err_thresh_i = 8'd1;
  logic        two_step_i = 1'b0, outer_sel_i = 1'b0, flt_adapt_i = 1'b0;
  logic [3:0]  eq_code_o;
  logic [2:0]  flt_code_o;
  logic        adapted_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  // reference model state
  int         m_st, m_t, m_e;
  logic [3:0] m_eq;
  logic [2:0] m_fl;

  always #5 clk = ~clk;

  eq_search_ctrl u_dut (
    .clk(clk), .rst(rst), .lock_i(lock_i),
    .err_clk_i(err_clk_i), .err_seq_i(err_seq_i), .err_par_i(err_par_i),
    .relock_period_i(relock_period_i), .err_mask_i(err_mask_i),
    .err_thresh_i(err_thresh_i), .two_step_i(two_step_i),
    .outer_sel_i(outer_sel_i), .flt_adapt_i(flt_adapt_i),
    .eq_code_o(eq_code_o), .flt_code_o(flt_code_o), .adapted_o(adapted_o)
  );

  task automatic chk(string tag, logic [3:0] eq_e, logic [2:0] fl_e, logic ad_e);
    n_chk++;
    if (eq_code_o !== eq_e || flt_code_o !== fl_e || adapted_o !== ad_e) begin
      n_fail++;
      $display("FAIL %s: eq=%0d flt=%0d adapted=%0b expected eq=%0d flt=%0d adapted=%0b",
               tag, eq_code_o, flt_code_o, adapted_o, eq_e, fl_e, ad_e);
    end
  endtask

  function automatic void model_advance();
    if (!flt_adapt_i) m_eq = m_eq + 1'b1;
    else if (!outer_sel_i) begin
      if (m_eq == 4'd15) m_fl = m_fl + 1'b1;
      m_eq = m_eq + 1'b1;
    end else begin
      if (m_fl == 3'd7) m_eq = m_eq + 1'b1;
      m_fl = m_fl + 1'b1;
    end
  endfunction

  function automatic void model_edge();
    int h, n, thr, enx, nst;
    bit done, adv;
    if (rst) begin
      m_st = 0; m_t = 0; m_e = 0; m_eq = '0; m_fl = '0;
      return;
    end
    h = int'(relock_period_i >> 1);
    if (h == 0) h = 1;
    n = int'(err_clk_i && err_mask_i[2]) + int'(err_seq_i && err_mask_i[1])
      + int'(err_par_i && err_mask_i[0]);
    thr = (err_thresh_i == 0) ? 1 : int'(err_thresh_i);
    done = (m_t == h - 1);
    enx = m_e + n;
    if (enx > 255) enx = 255;
    adv = 1'b0;
    nst = m_st;
    case (m_st)
      0: if (done) nst = 1;
      1: if (two_step_i && n > 0) adv = 1'b1;
         else if (done) begin
           if (lock_i && (two_step_i || enx <= thr)) nst = 2;
           else adv = 1'b1;
         end
      default: if (done && enx > thr) adv = 1'b1;
    endcase
    if (done || adv) begin m_t = 0; m_e = 0; end
    else begin
      m_t = m_t + 1;
      if (m_st != 0) m_e = enx;
    end
    if (adv) begin nst = 0; model_advance(); end
    m_st = nst;
  endfunction

  task automatic step(string tag);
    model_edge();
    @(posedge clk);
    #1;
    chk(tag, m_eq, m_fl, m_st == 2);
  endtask

  task automatic run(int cycles, string tag);
    for (int i = 0; i < cycles; i++) step(tag);
  endtask

  task automatic clear_err();
    err_clk_i = 1'b0; err_seq_i = 1'b0; err_par_i = 1'b0;
  endtask

  task automatic do_reset();
    clear_err();
    rst = 1'b1;
    step("R1");
    step("R1");
    rst = 1'b0;
    chk("R1", 4'd0, 3'd0, 1'b0);
  endtask

  task automatic cfg(int per, logic [2:0] mask, logic [7:0] thr, bit two, bit outer, bit flt);
    relock_period_i = 16'(per); err_mask_i = mask; err_thresh_i = thr;
    two_step_i = two; outer_sel_i = outer; flt_adapt_i = flt;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    #2;
    // R1 reset state
    cfg(10, 3'd0, 8'd1, 0, 0, 0);
    lock_i = 1'b1;
    do_reset();

    // R3 one-step: judged at the 2H-th edge (H=5)
    run(9, "R3");
    chk("R3", 4'd0, 3'd0, 1'b0);
    run(1, "R3");
    chk("R3", 4'd0, 3'd0, 1'b1);
    // R3 lock low at the judge edge advances
    do_reset();
    lock_i = 1'b0;
    run(10, "R3");
    chk("R3", 4'd1, 3'd0, 1'b0);
    lock_i = 1'b1;

    // R5 threshold 0 acts as 1
    cfg(10, 3'b001, 8'd0, 0, 0, 0);
    do_reset();
    run(6, "R5"); err_par_i = 1'b1; step("R5"); clear_err(); run(3, "R5");
    chk("R5", 4'd0, 3'd0, 1'b1);
    do_reset();
    run(6, "R5"); err_par_i = 1'b1; run(2, "R5"); clear_err(); run(2, "R5");
    chk("R5", 4'd1, 3'd0, 1'b0);

    // R2 mask selects error classes
    cfg(10, 3'b100, 8'd1, 0, 0, 0);
    do_reset(); err_par_i = 1'b1; run(10, "R2"); clear_err();
    chk("R2", 4'd0, 3'd0, 1'b1);
    cfg(10, 3'b001, 8'd1, 0, 0, 0);
    do_reset(); err_par_i = 1'b1; run(10, "R2"); clear_err();
    chk("R2", 4'd1, 3'd0, 1'b0);
    cfg(10, 3'b010, 8'd1, 0, 0, 0);
    do_reset(); err_seq_i = 1'b1; run(10, "R2"); clear_err();
    chk("R2", 4'd1, 3'd0, 1'b0);
    cfg(10, 3'b011, 8'd1, 0, 0, 0);
    do_reset(); err_clk_i = 1'b1; run(10, "R2"); clear_err();
    chk("R2", 4'd0, 3'd0, 1'b1);
    cfg(10, 3'b000, 8'd1, 0, 0, 0);
    do_reset(); err_clk_i = 1'b1; err_seq_i = 1'b1; err_par_i = 1'b1;
    run(10, "R2"); clear_err();
    chk("R2", 4'd0, 3'd0, 1'b1);

    // R6 saturation at 255 with threshold 255
    cfg(400, 3'b111, 8'd255, 0, 0, 0);
    do_reset(); err_clk_i = 1'b1; err_seq_i = 1'b1; err_par_i = 1'b1;
    run(400, "R6"); clear_err();
    chk("R6", 4'd0, 3'd0, 1'b1);

    // R4 two-step: phase-one errors ignored, phase-two error advances at once
    cfg(10, 3'b111, 8'd1, 1, 0, 0);
    do_reset(); err_seq_i = 1'b1; run(3, "R4"); clear_err(); run(7, "R4");
    chk("R4", 4'd0, 3'd0, 1'b1);
    do_reset(); run(5, "R4"); err_seq_i = 1'b1; step("R4"); clear_err();
    chk("R4", 4'd1, 3'd0, 1'b0);
    run(10, "R4");
    chk("R4", 4'd1, 3'd0, 1'b1);

    // R10 adapted monitoring over windows of H=5
    cfg(10, 3'b111, 8'd2, 0, 0, 0);
    do_reset(); run(10, "R10");
    err_clk_i = 1'b1; run(2, "R10"); clear_err(); run(3, "R10");
    chk("R10", 4'd0, 3'd0, 1'b1);
    err_clk_i = 1'b1; run(3, "R10"); clear_err(); run(2, "R10");
    chk("R10", 4'd1, 3'd0, 1'b0);

    // R7 equalizer-only search with wrap
    lock_i = 1'b0;
    cfg(2, 3'd0, 8'd1, 0, 0, 0);
    do_reset(); run(30, "R7");
    chk("R7", 4'd15, 3'd0, 1'b0);
    run(2, "R7");
    chk("R7", 4'd0, 3'd0, 1'b0);

    // R8 equalizer inner loop
    cfg(2, 3'd0, 8'd1, 0, 0, 1);
    do_reset(); run(32, "R8");
    chk("R8", 4'd0, 3'd1, 1'b0);
    run(224, "R8");
    chk("R8", 4'd0, 3'd0, 1'b0);

    // R9 filter inner loop
    cfg(2, 3'd0, 8'd1, 0, 1, 1);
    do_reset(); run(16, "R9");
    chk("R9", 4'd1, 3'd0, 1'b0);
    run(6, "R9");
    chk("R9", 4'd1, 3'd3, 1'b0);

    // random segments against the reference model
    for (int s = 0; s < 24; s++) begin
      string tag;
      cfg(int'($urandom_range(0, 24)), 3'($urandom_range(0, 7)), 8'($urandom_range(0, 4)),
          bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
      tag = two_step_i ? "R4" : "R3";
      do_reset();
      for (int c = 0; c < 250; c++) begin
        lock_i    = ($urandom_range(0, 9) != 0);
        err_clk_i = ($urandom_range(0, 15) == 0);
        err_seq_i = ($urandom_range(0, 15) == 0);
        err_par_i = ($urandom_range(0, 15) == 0);
        step(tag);
      end
      clear_err();
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule